// File: doc/BRIEF.md
# Input Handshake Port Controller

This block is one 8-bit input port that a peripheral fills under a strobe handshake and a processor empties through a decoded I/O read. The peripheral holds `per_stb_n` low while `per_data` is valid. During that time the port keeps copying the data into its holding register. When the strobe returns high, the port reports the register full by dropping `per_rdy`. It can also raise an interrupt request, if interrupts are enabled and no higher-priority device in the chain is being served. When the processor finishes reading the register, `per_rdy` returns high and the port can take the next byte.

Every `per_rdy` change happens on a rising edge of `clk`. That edge stands for the falling edge of the processor clock, so each cycle of `clk` is one processor clock period. If the processor reads the port while it is empty, `per_rdy` is forced low for as long as the read lasts. A peripheral that strobes only while `per_rdy` is high therefore cannot change the register while it is being read.

The handshake is built as a state machine with six states:
- EMPTY: ready, idle.
- LOAD: ready, strobe low, capturing.
- RD_LEAD: ready, first cycle of a read of an empty port.
- FORCED: not ready, the rest of that read.
- FULL: not ready, data waiting.
- FULL_RD: not ready, the processor is reading a full port.

The transitions are:
- EMPTY→LOAD when the strobe is low and there is no read.
- EMPTY→RD_LEAD when a read is decoded. A read wins over a strobe in the same cycle.
- LOAD→FULL when the strobe is seen high.
- RD_LEAD→FORCED when the read is still active.
- RD_LEAD→EMPTY when the read has already ended.
- FORCED→EMPTY when the read ends.
- FULL→FULL_RD when a read is decoded.
- FULL_RD→EMPTY when the read ends.

Top module: `hip_in_port`

## Requirements
- R1: After reset, `per_rdy` is 1 and `int_req_n` is 1. The interrupt-enable flag is also cleared, so a completed strobe with no enable write does not pull `int_req_n` low.
- R2: In EMPTY with no read decoded, or in LOAD, every clock edge that samples `per_stb_n` low copies `per_data` into the register. The value kept is the one sampled at the last low edge.
- R3: The first clock edge that samples `per_stb_n` high in LOAD moves the port to FULL, and `per_rdy` goes to 0 at that edge.
- R4: A strobe while `per_rdy` is 0 leaves the register unchanged. A later read returns the earlier byte.
- R5: A read is decoded only when `cpu_rd_n`, `chip_sel_n`, `ctl_sel` and `cpu_io_n` are all 0. While the read is decoded, `cpu_doe` is 1 and `cpu_dout` shows the register. At other times `cpu_doe` is 0 and `cpu_dout` is 0. A partial decode does not change the handshake.
- R6: After a read of a full port, `per_rdy` returns to 1 at the first clock edge that samples the read as inactive.
- R7: A read of an empty port keeps `per_rdy` at 1 at the first edge and forces it to 0 at the second edge if the read is still decoded. `per_rdy` goes back to 1 at the first edge that samples the read as ended. A one-cycle read never drops `per_rdy`.
- R8: `int_req_n` goes to 0 at the same edge as the move to FULL, but only if the enable flag and `chain_in` were 1 before that edge. It returns to 1 at the edge where a read of the full port is first decoded.
- R9: `chain_out` is 1 only while `chain_in` is 1 and no request of this port is pending.
- R10: A clock edge with `ien_we` at 1 loads `ien_d` into the interrupt-enable flag. The request logic uses the new value from the next edge on.
- R11: A strobe during RD_LEAD or FORCED, that is during a read of an empty port, is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge marks one processor clock falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_stb_n | input | 1 | Peripheral strobe, active low |
| per_data | input | DATA_W | Peripheral data |
| per_rdy | output | 1 | High when the port can accept data |
| cpu_rd_n | input | 1 | Processor read, active low |
| cpu_io_n | input | 1 | Processor I/O request, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| ctl_sel | input | 1 | 1 selects control, 0 selects data |
| cpu_dout | output | DATA_W | Read data, 0 when not reading |
| cpu_doe | output | 1 | Read data valid |
| ien_we | input | 1 | Interrupt-enable write |
| ien_d | input | 1 | Interrupt-enable value |
| chain_in | input | 1 | Priority chain in, 1 = no higher device active |
| chain_out | output | 1 | Priority chain out |
| int_req_n | output | 1 | Interrupt request, active low |

## Verification
The handshake is tried with several input patterns:
- Short and long strobes with changing data, which separate last-value capture from first-value capture.
- Strobes that arrive while the port is full, which show whether loads are blocked.
- Reads of a full port against reads of an empty port, including one-cycle reads and strobes during a read, which separate the normal release of `per_rdy` from the forced low.
- Read attempts with each decode term missing, which show whether the decode needs every term.
- Strobes with the enable flag clear, with `chain_in` low, and with both set, which separate the interrupt gating conditions.

// File: rtl/hip_pkg.sv
package hip_pkg;
    typedef enum logic [2:0] {
        S_EMPTY   = 3'd0,
        S_LOAD    = 3'd1,
        S_RD_LEAD = 3'd2,
        S_FORCED  = 3'd3,
        S_FULL    = 3'd4,
        S_FULL_RD = 3'd5
    } hs_state_t;
endpackage

// File: rtl/hip_rd_decode.sv
module hip_rd_decode (
    input  logic cpu_rd_n,
    input  logic cpu_io_n,
    input  logic chip_sel_n,
    input  logic ctl_sel,
    output logic rd_act
);
    // data read: every term active
    always_comb begin
        rd_act = !cpu_rd_n && !cpu_io_n && !chip_sel_n && !ctl_sel;
    end
endmodule

// File: rtl/hip_capture.sv
module hip_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= din;
        end
    end
endmodule

// File: rtl/hip_fsm.sv
module hip_fsm
    import hip_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb_n,
    input  logic      rd_act,
    output hs_state_t st_o,
    output logic      ready,
    output logic      load_en,
    output logic      full_done,
    output logic      rd_full_start
);
    hs_state_t st_q;
    hs_state_t st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_EMPTY: begin
                if (rd_act) begin
                    st_d = S_RD_LEAD;
                end else if (!stb_n) begin
                    st_d = S_LOAD;
                end
            end
            S_LOAD: begin
                if (stb_n) begin
                    st_d = S_FULL;
                end
            end
            S_RD_LEAD: begin
                st_d = rd_act ? S_FORCED : S_EMPTY;
            end
            S_FORCED: begin
                if (!rd_act) begin
                    st_d = S_EMPTY;
                end
            end
            S_FULL: begin
                if (rd_act) begin
                    st_d = S_FULL_RD;
                end
            end
            S_FULL_RD: begin
                if (!rd_act) begin
                    st_d = S_EMPTY;
                end
            end
            default: st_d = S_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        st_o          = st_q;
        ready         = (st_q == S_EMPTY) || (st_q == S_LOAD) || (st_q == S_RD_LEAD);
        load_en       = !stb_n && ((st_q == S_LOAD) || ((st_q == S_EMPTY) && !rd_act));
        full_done     = (st_q == S_LOAD) && stb_n;
        rd_full_start = (st_q == S_FULL) && rd_act;
    end
endmodule

// File: rtl/hip_irq.sv
module hip_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ien_we,
    input  logic ien_d,
    input  logic set_req,
    input  logic clr_req,
    input  logic chain_in,
    output logic ie_q,
    output logic chain_out,
    output logic int_req_n
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ien_we) begin
            ie_q <= ien_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_req && ie_q && chain_in) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        int_req_n = !pend_q;
        chain_out = chain_in && !pend_q;
    end
endmodule

// File: rtl/hip_in_port.sv
module hip_in_port
    import hip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_stb_n,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_rdy,
    input  logic              cpu_rd_n,
    input  logic              cpu_io_n,
    input  logic              chip_sel_n,
    input  logic              ctl_sel,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              cpu_doe,
    input  logic              ien_we,
    input  logic              ien_d,
    input  logic              chain_in,
    output logic              chain_out,
    output logic              int_req_n
);
    logic              rd_act;
    logic              load_en;
    logic              full_done;
    logic              rd_full_start;
    logic              ie_q;
    logic [DATA_W-1:0] data_q;
    hs_state_t         st;

    hip_rd_decode u_dec (
        .cpu_rd_n   (cpu_rd_n),
        .cpu_io_n   (cpu_io_n),
        .chip_sel_n (chip_sel_n),
        .ctl_sel    (ctl_sel),
        .rd_act     (rd_act)
    );

    hip_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb_n         (per_stb_n),
        .rd_act        (rd_act),
        .st_o          (st),
        .ready         (per_rdy),
        .load_en       (load_en),
        .full_done     (full_done),
        .rd_full_start (rd_full_start)
    );

    hip_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .din     (per_data),
        .q       (data_q)
    );

    hip_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_we    (ien_we),
        .ien_d     (ien_d),
        .set_req   (full_done),
        .clr_req   (rd_full_start),
        .chain_in  (chain_in),
        .ie_q      (ie_q),
        .chain_out (chain_out),
        .int_req_n (int_req_n)
    );

    always_comb begin
        cpu_doe  = rd_act;
        cpu_dout = rd_act ? data_q : '0;
    end
endmodule

// File: rtl/hip_chk.sv
module hip_chk
    import hip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_rdy,
    input logic              rd_act,
    input logic              ie_q,
    input logic              chain_in,
    input logic              chain_out,
    input logic              int_req_n,
    input logic              cpu_doe,
    input logic [DATA_W-1:0] cpu_dout,
    input logic [DATA_W-1:0] data_q,
    input hs_state_t         st
);
    // R4
    hold_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rdy |=> $stable(data_q));

    // R11
    no_load_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_LEAD || st == S_FORCED) |=> $stable(data_q));

    // R5
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_doe |-> (cpu_dout == '0));

    // R7
    forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_LEAD && rd_act) |=> !per_rdy);

    // R6
    release_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rdy) |-> !$past(rd_act));

    // R8
    irq_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_req_n) |-> ($fell(per_rdy) && $past(ie_q) && $past(chain_in)));

    // R9
    chain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req_n |-> !chain_out);
endmodule

bind hip_in_port hip_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_rdy   (per_rdy),
    .rd_act    (rd_act),
    .ie_q      (ie_q),
    .chain_in  (chain_in),
    .chain_out (chain_out),
    .int_req_n (int_req_n),
    .cpu_doe   (cpu_doe),
    .cpu_dout  (cpu_dout),
    .data_q    (data_q),
    .st        (st)
);

// File: tb/sim_hip_in_port.sv
`timescale 1ns/100ps
module sim_hip_in_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         per_stb_n = 1'b1;
    logic [W-1:0] per_data = '0;
    logic         per_rdy;
    logic         cpu_rd_n = 1'b1;
    logic         cpu_io_n = 1'b1;
    logic         chip_sel_n = 1'b0;
    logic         ctl_sel = 1'b0;
    logic [W-1:0] cpu_dout;
    logic         cpu_doe;
    logic         ien_we = 1'b0;
    logic         ien_d = 1'b0;
    logic         chain_in = 1'b1;
    logic         chain_out;
    logic         int_req_n;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference
    bit       m_full, m_loading, m_inrd, m_irq, m_ie;
    int       m_rdn;
    logic [W-1:0] m_data;

    always #2.5 clk = ~clk;

    hip_in_port #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .per_stb_n(per_stb_n), .per_data(per_data),
        .per_rdy(per_rdy), .cpu_rd_n(cpu_rd_n), .cpu_io_n(cpu_io_n),
        .chip_sel_n(chip_sel_n), .ctl_sel(ctl_sel), .cpu_dout(cpu_dout),
        .cpu_doe(cpu_doe), .ien_we(ien_we), .ien_d(ien_d), .chain_in(chain_in),
        .chain_out(chain_out), .int_req_n(int_req_n)
    );

    function automatic bit read_seen();
        return !cpu_rd_n && !cpu_io_n && !chip_sel_n && !ctl_sel;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        bit rd;
        bit ie_prev;
        if (!rst_n) begin
            m_full = 0; m_loading = 0; m_inrd = 0; m_rdn = 0;
            m_irq = 0; m_ie = 0; m_data = '0;
        end else begin
            rd = read_seen();
            ie_prev = m_ie;
            if (ien_we) m_ie = ien_d;
            if (m_loading) begin
                if (!per_stb_n) m_data = per_data;
                else begin
                    m_loading = 0; m_full = 1;
                    if (ie_prev && chain_in) m_irq = 1;
                end
            end else if (m_inrd) begin
                if (!rd) begin m_inrd = 0; m_rdn = 0; m_full = 0; end
                else if (m_rdn < 2) m_rdn++;
            end else if (rd) begin
                m_inrd = 1; m_rdn = 1;
                if (m_full) m_irq = 0;
            end else if (!m_full && !per_stb_n) begin
                m_loading = 1; m_data = per_data;
            end
        end
    end

    always @(negedge clk) begin : compare
        bit rd;
        if (rst_n && cmp_on) begin
            rd = read_seen();
            check(cur_req, "per_rdy", per_rdy, !m_full && !(m_inrd && m_rdn >= 2));
            check(cur_req, "int_req_n", int_req_n, !m_irq);
            check("R9", "chain_out", chain_out, chain_in && !m_irq);
            check("R5", "cpu_doe", cpu_doe, rd);
            check("R5", "cpu_dout", cpu_dout, rd ? m_data : '0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic strobe(logic [W-1:0] d, int len);
        per_data = d; per_stb_n = 1'b0;
        tick(len);
        per_stb_n = 1'b1;
        tick(1);
    endtask

    task automatic cpu_read(int len, output logic [W-1:0] seen);
        cpu_rd_n = 1'b0; cpu_io_n = 1'b0;
        @(negedge clk);
        seen = cpu_dout;
        if (len > 1) repeat (len - 1) @(negedge clk);
        #1;
        cpu_rd_n = 1'b1; cpu_io_n = 1'b1;
        tick(1);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1'b1;
        // R1 reset state
        check("R1", "per_rdy after reset", per_rdy, 1);
        check("R1", "int_req_n after reset", int_req_n, 1);

        // R3 / R1: strobe with interrupt enable still cleared
        cur_req = "R3";
        strobe(8'hA5, 3);
        check("R3", "per_rdy after strobe", per_rdy, 0);
        check("R1", "no irq while ie clear", int_req_n, 1);

        // R2 / R6 read of full port
        cur_req = "R6";
        cpu_read(2, v);
        check("R2", "read value", v, 8'hA5);
        check("R6", "per_rdy after read", per_rdy, 1);

        // R10 enable write, R8 irq
        cur_req = "R10";
        ien_we = 1'b1; ien_d = 1'b1;
        tick(1);
        ien_we = 1'b0;
        cur_req = "R8";
        strobe(8'h3C, 2);
        check("R8", "irq raised", int_req_n, 0);
        check("R9", "chain blocked", chain_out, 0);

        // R4 strobe while full ignored
        cur_req = "R4";
        strobe(8'hFF, 2);
        tick(1);
        cpu_read(1, v);
        check("R4", "old byte kept", v, 8'h3C);
        check("R8", "irq cleared by read", int_req_n, 1);

        // R7 / R11 read of empty port with strobe inside
        cur_req = "R7";
        cpu_rd_n = 1'b0; cpu_io_n = 1'b0;
        tick(1);
        check("R7", "ready at first edge", per_rdy, 1);
        cur_req = "R11";
        per_data = 8'h11; per_stb_n = 1'b0;
        tick(1);
        check("R7", "forced low", per_rdy, 0);
        tick(2);
        per_stb_n = 1'b1;
        cpu_rd_n = 1'b1; cpu_io_n = 1'b1;
        tick(1);
        check("R7", "ready back", per_rdy, 1);
        cpu_read(1, v);
        check("R11", "strobe in read ignored", v, 8'h3C);
        check("R7", "one-cycle read keeps ready", per_rdy, 1);

        // R8 / R9 chain_in low blocks irq
        cur_req = "R9";
        chain_in = 1'b0;
        strobe(8'h5A, 1);
        check("R8", "no irq with chain low", int_req_n, 1);
        check("R9", "chain_out low", chain_out, 0);
        chain_in = 1'b1;
        tick(1);

        // R5 partial decodes do nothing
        cur_req = "R5";
        ctl_sel = 1'b1;
        cpu_read(3, v);
        check("R5", "ctl select no drive", v, 0);
        ctl_sel = 1'b0; chip_sel_n = 1'b1;
        cpu_read(3, v);
        check("R5", "no chip select no drive", v, 0);
        chip_sel_n = 1'b0;
        cpu_io_n = 1'b0;
        tick(3);
        cpu_io_n = 1'b1;
        tick(1);
        check("R5", "still full", per_rdy, 0);
        cpu_read(2, v);
        check("R5", "full decode value", v, 8'h5A);

        // R2 long strobe with changing data
        cur_req = "R2";
        per_stb_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            per_data = W'(8'h40 + i);
            tick(1);
        end
        per_stb_n = 1'b1;
        tick(1);
        check("R8", "irq after long strobe", int_req_n, 0);
        cpu_read(2, v);
        check("R2", "last value kept", v, 8'h45);

        // R10 disable again
        cur_req = "R10";
        ien_we = 1'b1; ien_d = 1'b0;
        tick(1);
        ien_we = 1'b0;
        strobe(8'h77, 2);
        check("R10", "irq off after disable", int_req_n, 1);
        cpu_read(1, v);
        check("R2", "value 77", v, 8'h77);

        tick(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule